// File: doc/BRIEF.md
# Three-parallel fast FIR filter

This block is a fixed-coefficient FIR filter of `NTAPS` taps that takes three consecutive input samples on every accepted clock and delivers the three matching output samples one clock later. It serves stream rates three times the clock rate. Each clock carries one block of three samples. The lane `x0` holds the oldest sample of the block and `x2` the newest. The outputs follow the same lane order.

The coefficients are split by index modulo three into three phase filters, each of `NTAPS/3` taps. The block does not spend nine phase-by-phase sub-filters on the convolution. It uses six third-length transposed-form sub-filters instead. Three of them are fed by the plain lanes and three by pre-added lane sums (lanes 0+1, lanes 1+2, and all three lanes). A small post-adder network then combines the six results. Two terms of that network are carried across one block through registers. `in_valid` gates every register of the filter, so idle cycles neither advance the filter history nor change the outputs.

Top module: `fir3_fast`

## Requirements
- R1: For block k, with x(3k)=`x0`, x(3k+1)=`x1` and x(3k+2)=`x2`, the outputs are `y0`=y(3k), `y1`=y(3k+1) and `y2`=y(3k+2), where y(n)=Σ h(i)·x(n−i) over i=0..NTAPS−1. Samples before the first block after reset count as zero. All values are two's complement.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, and the outputs for a block appear together with that strobe.
- R3: In a clock with `in_valid` low, the input lanes are ignored: the outputs hold their values and the filter history does not advance, so the stream after the gap continues as if the gap were absent.
- R4: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` low and all three outputs zero. No sample accepted before the reset affects any output after it.
- R5: Results are exact over the full input and coefficient range, including −2^(DW−1). The output width is DW+CW+clog2(NTAPS), which cannot overflow.
- R6: Any NTAPS that is a positive multiple of three is supported. Coefficient h(i) is taken from `COEFS[i*CW +: CW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The three lanes carry a new block |
| x0 | input | DW | Oldest sample of the block |
| x1 | input | DW | Middle sample of the block |
| x2 | input | DW | Newest sample of the block |
| out_valid | output | 1 | The three outputs carry a new block |
| y0 | output | OW | Output for the oldest position |
| y1 | output | OW | Output for the middle position |
| y2 | output | OW | Output for the newest position |

## Verification
The bench targets the terms that cross a block boundary. A wrong carried delay on the lane-2 product or the cross term would corrupt `y0` and `y1` as soon as a sample has moved into the previous block. Idle cycles with garbage on the lanes are inserted between valid blocks. A design that let the sub-filters or the carried registers advance on such cycles would shift the whole following stream. Runs of full-scale negative and alternating extreme samples against coefficients that include −128 expose an intermediate or output width that is too narrow. A reset in the middle of a stream, followed by an impulse, shows any history the reset failed to clear. Three tap counts (6, 12 and 24) are run side by side, which covers two-tap phase filters and longer ones.

// File: rtl/fir3_fast.sv
module fir3_fast #(
  parameter int NTAPS = 12,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [NTAPS*CW-1:0] COEFS = 96'h05_80_7F_0A_F6_13_ED_22_DE_40_C0_01,
  parameter int OW = DW + CW + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  output logic                 out_valid,
  output logic signed [OW-1:0] y0,
  output logic signed [OW-1:0] y1,
  output logic signed [OW-1:0] y2
);

  localparam int M  = NTAPS / 3;
  localparam int SW = DW + 2;
  localparam int HW = CW + 2;
  localparam int IW = DW + CW + 5 + $clog2(M);

  function automatic logic signed [HW-1:0] phase_coef(int ph, int j);
    return HW'($signed(COEFS[(3*j+ph)*CW +: CW]));
  endfunction

  function automatic logic signed [HW-1:0] sub_coef(int k, int j);
    case (k)
      0: return phase_coef(0, j);
      1: return phase_coef(1, j);
      2: return phase_coef(2, j);
      3: return phase_coef(0, j) + phase_coef(1, j);
      4: return phase_coef(1, j) + phase_coef(2, j);
      default: return phase_coef(0, j) + phase_coef(1, j) + phase_coef(2, j);
    endcase
  endfunction

  logic signed [SW-1:0] xs [6];
  logic signed [IW-1:0] p  [6];

  assign xs[0] = SW'(x0);
  assign xs[1] = SW'(x1);
  assign xs[2] = SW'(x2);
  assign xs[3] = SW'(x0) + SW'(x1);
  assign xs[4] = SW'(x1) + SW'(x2);
  assign xs[5] = xs[3] + SW'(x2);

  for (genvar k = 0; k < 6; k++) begin : g_sub
    logic signed [IW-1:0] tap [M];
    logic signed [IW-1:0] r   [M];

    for (genvar j = 0; j < M; j++) begin : g_tap
      localparam logic signed [HW-1:0] HC = sub_coef(k, j);
      assign tap[j] = IW'(xs[k]) * IW'(HC) + r[j];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < M; j++) r[j] <= '0;
      end else if (in_valid) begin
        for (int j = 0; j < M - 1; j++) r[j] <= tap[j+1];
      end
    end

    assign p[k] = tap[0];
  end

  logic signed [IW-1:0] t0, t1, t2, d2, dt2;

  assign t1 = p[3] - p[1];
  assign t2 = p[4] - p[1];
  assign t0 = p[0] - d2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d2        <= '0;
      dt2       <= '0;
      y0        <= '0;
      y1        <= '0;
      y2        <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        d2  <= p[2];
        dt2 <= t2;
        y0  <= OW'(t0 + dt2);
        y1  <= OW'(t1 - t0);
        y2  <= OW'(p[5] - t1 - t2);
      end
    end
  end

endmodule

// File: rtl/fir3_fast_chk.sv
module fir3_fast_chk #(
  parameter int OW = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] y0,
  input logic signed [OW-1:0] y1,
  input logic signed [OW-1:0] y2
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && y0 == '0 && y1 == '0 && y2 == '0)); // R4

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y0) && $stable(y1) && $stable(y2))); // R3

endmodule

bind fir3_fast fir3_fast_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .y0(y0), .y1(y1), .y2(y2)
);

// File: tb/sim_fir3_fast.sv
module sim_fir3_fast;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam logic [47:0]  C6  = 48'h80_7F_03_FD_11_EE;
  localparam logic [95:0]  C12 = 96'h05_80_7F_0A_F6_13_ED_22_DE_40_C0_01;
  localparam logic [191:0] C24 = 192'h0102030405060708_F8F7F6F5F4F3F2F1_7F80193A5CA3C5E7;

  localparam int VEC [16][3] = '{
    '{1, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, '{0, 1, 0},
    '{0, 0, 0}, '{0, 0, 0}, '{0, 0, -1}, '{0, 0, 0},
    '{5, -7, 9}, '{-128, 127, -128}, '{127, 127, 127}, '{-1, -1, -1},
    '{3, 0, -3}, '{64, -64, 32}, '{0, 0, 0}, '{0, 0, 0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic signed [7:0] a0 = '0, a1 = '0, a2 = '0;
  logic ov0, ov1, ov2;
  logic signed [19:0] m0, m1, m2;
  logic signed [18:0] s0, s1, s2;
  logic signed [20:0] l0, l1, l2;

  fir3_fast #(.NTAPS(12), .DW(DW), .CW(CW), .COEFS(C12)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .x0(a0), .x1(a1), .x2(a2),
    .out_valid(ov0), .y0(m0), .y1(m1), .y2(m2));
  fir3_fast #(.NTAPS(6), .DW(DW), .CW(CW), .COEFS(C6)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .x0(a0), .x1(a1), .x2(a2),
    .out_valid(ov1), .y0(s0), .y1(s1), .y2(s2));
  fir3_fast #(.NTAPS(24), .DW(DW), .CW(CW), .COEFS(C24)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .x0(a0), .x1(a1), .x2(a2),
    .out_valid(ov2), .y0(l0), .y1(l1), .y2(l2));

  int nchk = 0;
  int nfail = 0;
  int hist [4096];
  int nh = 0;

  function automatic int ntaps(int d);
    return (d == 0) ? 12 : (d == 1) ? 6 : 24;
  endfunction

  function automatic int coef(int d, int i);
    logic signed [7:0] c;
    case (d)
      0: c = C12[i*8 +: 8];
      1: c = C6[i*8 +: 8];
      default: c = C24[i*8 +: 8];
    endcase
    return int'(c);
  endfunction

  function automatic longint ref_y(int d, int t);
    longint acc = 0;
    for (int i = 0; i < ntaps(d); i++)
      if (t - i >= 0) acc += longint'(coef(d, i)) * longint'(hist[t-i]);
    return acc;
  endfunction

  function automatic longint outv(int d, int lane);
    case (d)
      0: return (lane == 0) ? longint'(m0) : (lane == 1) ? longint'(m1) : longint'(m2);
      1: return (lane == 0) ? longint'(s0) : (lane == 1) ? longint'(s1) : longint'(s2);
      default: return (lane == 0) ? longint'(l0) : (lane == 1) ? longint'(l1) : longint'(l2);
    endcase
  endfunction

  function automatic logic ovd(int d);
    return (d == 0) ? ov0 : (d == 1) ? ov1 : ov2;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int b0, input int b1, input int b2, input bit v, input string tag);
    longint prev [3][3];
    for (int d = 0; d < 3; d++)
      for (int q = 0; q < 3; q++) prev[d][q] = outv(d, q);
    a0 = 8'(b0); a1 = 8'(b1); a2 = 8'(b2); vin = v;
    if (v) begin
      hist[nh] = b0; hist[nh+1] = b1; hist[nh+2] = b2;
      nh += 3;
    end
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      string tg = (d == 0) ? tag : {tag, "/R6"};
      chk("R2 valid", longint'(ovd(d)), longint'(v));
      for (int q = 0; q < 3; q++) begin
        if (v) chk(tg, outv(d, q), ref_y(d, nh - 3 + q));
        else   chk("R3 hold", outv(d, q), prev[d][q]);
      end
    end
  endtask

  task automatic do_reset();
    vin = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R4 valid low", longint'(ovd(d)), 0);
      for (int q = 0; q < 3; q++) chk("R4 zero out", outv(d, q), 0);
    end
    rst_n = 1'b1;
    nh = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #(8 * 150000);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    do_reset();

    for (int r = 0; r < 16; r++) step(VEC[r][0], VEC[r][1], VEC[r][2], 1'b1, "R1");

    step(11, -22, 33, 1'b1, "R1");
    step(-99, 77, -55, 1'b0, "R3");
    step(127, -128, 1, 1'b0, "R3");
    step(4, 5, 6, 1'b1, "R3");
    step(-100, 50, 0, 1'b0, "R3");
    for (int r = 0; r < 8; r++) step(0, 0, 0, 1'b1, "R3");

    for (int r = 0; r < 10; r++) step(-128, -128, -128, 1'b1, "R5");
    for (int r = 0; r < 10; r++) step(127, -128, 127, 1'b1, "R5");
    for (int r = 0; r < 10; r++) step(-128, 127, -128, 1'b1, "R5");

    for (int r = 0; r < 300; r++) begin
      bit v = ($urandom % 5) != 0;
      step(int'($urandom % 256) - 128, int'($urandom % 256) - 128,
           int'($urandom % 256) - 128, v, v ? "R1" : "R3");
    end

    for (int r = 0; r < 5; r++) step(90, -90, 45, 1'b1, "R1");
    do_reset();
    step(0, 1, 0, 1'b1, "R4");
    for (int r = 0; r < 10; r++) step(0, 0, 0, 1'b1, "R4");

    summary();
    $finish;
  end
endmodule